// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the coherence state of a small table of cache lines in a private cache that sits on a shared snooping bus with one other cache. Every line is held as Invalid, Shared or Exclusive. Invalid means the stored value may not be used. Shared is a read-only copy. Exclusive is the only state that can be written, and it may hold data newer than memory. Each line holds one data word kept in registers, so a line fill or a local write replaces the whole line.

The local side presents one read or write at a time. Hits complete one cycle later. A miss, or a write to a Shared line, raises a bus request that is held until the bus returns a fill strobe. The snoop side observes the requests of the other cache. When the snooped line is held Exclusive, the controller answers with the data in the cycle after the snoop, so that memory stays silent. A snooped read also asks memory to take a copy, because the line drops to Shared. A snooped read-exclusive or upgrade drops the line to Invalid. Line addresses index the table directly. The line count is a power of two.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset, every line is Invalid, `lreq_ready` is 1, and `bus_req_valid`, `lrsp_valid` and `snp_supply` are 0.
- R2: A local read accepted on a Shared or Exclusive line gives `lrsp_valid`=1 with the stored word on the next cycle, and issues no bus request.
- R3: A local read accepted on an Invalid line drives `bus_req_valid`=1 with `bus_req_op`=2'b01 (read) and the line index from the next cycle on. The request is held until `bus_fill_valid`. In the cycle after the fill, `lrsp_valid`=1 with the fill data, and the line is Shared.
- R4: A local write accepted on an Exclusive line stores the word with no bus traffic. It answers with `lrsp_valid`=1 on the next cycle, with the written word on `lrsp_rdata`, and the line stays Exclusive.
- R5: A local write to a Shared line issues `bus_req_op`=2'b11 (upgrade). A local write to an Invalid line issues 2'b10 (read-exclusive). After the fill, the line is Exclusive and holds the written word. The fill data is ignored, and the written word is returned on `lrsp_rdata`.
- R6: A snooped read (`snp_op`=2'b01) to an Exclusive line gives `snp_supply`=1 and `snp_wb`=1 with the line's word on `snp_data` in the next cycle. The line becomes Shared.
- R7: A snooped read-exclusive (2'b10) or upgrade (2'b11) to an Exclusive line gives `snp_supply`=1 with the line's word and `snp_wb`=0 in the next cycle. The line becomes Invalid.
- R8: A snooped read-exclusive or upgrade to a Shared line makes it Invalid with no supply.
- R9: A snooped read to a Shared line, or any snoop to an Invalid line, changes no state and gives no supply.
- R10: `lreq_ready` is 0 while `snp_valid` is 1 and while a bus request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local access present |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_line | input | IDX_W | Line index of local access |
| lreq_wdata | input | DATA_W | Write word |
| lreq_ready | output | 1 | Local access accepted this cycle |
| lrsp_valid | output | 1 | Local access complete |
| lrsp_rdata | output | DATA_W | Read word, or written word for writes |
| bus_req_valid | output | 1 | Bus transaction outstanding |
| bus_req_op | output | 2 | 01 read, 10 read-exclusive, 11 upgrade |
| bus_req_line | output | IDX_W | Line of the bus transaction |
| bus_fill_valid | input | 1 | Bus transaction done |
| bus_fill_data | input | DATA_W | Returned line word |
| snp_valid | input | 1 | Snooped request from the other cache |
| snp_op | input | 2 | Snooped op, same encoding as `bus_req_op` |
| snp_line | input | IDX_W | Snooped line index |
| snp_supply | output | 1 | This cache answers the snoop; memory must not |
| snp_wb | output | 1 | Memory must also capture `snp_data` |
| snp_data | output | DATA_W | Supplied word |

## Verification
The local side is tried with reads and writes against lines in each of the three states. Whether a bus request appears, and which op it carries, tells Invalid, Shared and Exclusive apart at the ports. Each snoop op is aimed at Exclusive, Shared and Invalid lines. The supply and writeback pair separates the downgrade from the invalidation. A later local access to the same line shows the state the snoop left behind. Fills that carry data different from the written word show that writes keep their own data, and a second line index shows that lines do not disturb one another.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_RDX  = 2'd2,
        OP_UPG  = 2'd3
    } bus_op_e;

    // State a line takes after another cache's request is observed.
    function automatic line_st_e snoop_next(line_st_e cur, bus_op_e op);
        line_st_e nxt;
        nxt = cur;
        case (op)
            OP_RD:          if (cur == ST_E) nxt = ST_S;
            OP_RDX, OP_UPG: nxt = ST_I;
            default:        nxt = cur;
        endcase
        return nxt;
    endfunction

    // Bus op a local access needs; OP_NONE means it hits.
    function automatic bus_op_e miss_op(line_st_e cur, logic is_wr);
        bus_op_e op;
        case (cur)
            ST_I:    op = is_wr ? OP_RDX : OP_RD;
            ST_S:    op = is_wr ? OP_UPG : OP_NONE;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic logic owner_supplies(line_st_e cur);
        return cur == ST_E;
    endfunction

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_line,
    output line_st_e          lk_state,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_line,
    output line_st_e          sn_cur_state,
    output logic [DATA_W-1:0] sn_cur_data,
    input  logic              sn_upd,
    input  line_st_e          sn_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_line,
    input  line_st_e          wr_state,
    input  logic [DATA_W-1:0] wr_data
);

    line_st_e          st_all  [NLINES];
    logic [DATA_W-1:0] dat_all [NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_st_e          st_r;
        logic [DATA_W-1:0] d_r;
        wire hit_wr = wr_en  && (wr_line == IDX_W'(i));
        wire hit_sn = sn_upd && (sn_line == IDX_W'(i));

        // a local install or write wins over a snoop in the same cycle
        always_ff @(posedge clk) begin
            if (rst) begin
                st_r <= ST_I;
                d_r  <= '0;
            end else if (hit_wr) begin
                st_r <= wr_state;
                d_r  <= wr_data;
            end else if (hit_sn) begin
                st_r <= sn_state;
            end
        end

        assign st_all[i]  = st_r;
        assign dat_all[i] = d_r;
    end

    assign lk_state     = st_all[lk_line];
    assign lk_data      = dat_all[lk_line];
    assign sn_cur_state = st_all[sn_line];
    assign sn_cur_data  = dat_all[sn_line];

    // R7 / R8: a snooped request never promotes a line to Exclusive
    p_snoop_no_promote_r7: assert property (@(posedge clk) disable iff (rst)
        sn_upd |-> sn_state != ST_E);

    // R5: local installs are always readable states, never Invalid
    p_install_valid_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_state != ST_I);

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  line_st_e          cur_state,
    input  logic [DATA_W-1:0] cur_data,
    output logic              upd,
    output line_st_e          nxt_state,
    output logic              supply,
    output logic              wb,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        nxt_state = snoop_next(cur_state, snp_op);
        upd       = snp_valid && (nxt_state != cur_state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            supply <= 1'b0;
            wb     <= 1'b0;
            data   <= '0;
        end else begin
            supply <= snp_valid && owner_supplies(cur_state);
            wb     <= snp_valid && owner_supplies(cur_state) && (snp_op == OP_RD);
            data   <= cur_data;
        end
    end

    // R6: a memory writeback is only ever paired with a cache supply
    p_wb_with_supply_r6: assert property (@(posedge clk) disable iff (rst)
        wb |-> supply);

    // R9: a snoop to an Invalid line leaves it untouched
    p_invalid_untouched_r9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && cur_state == ST_I) |-> !upd);

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lreq_valid,
    input  logic              lreq_write,
    input  logic [IDX_W-1:0]  lreq_line,
    input  logic [DATA_W-1:0] lreq_wdata,
    output logic              lreq_ready,
    input  logic              snp_valid,
    output logic [IDX_W-1:0]  lk_line,
    input  line_st_e          lk_state,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_line,
    output line_st_e          wr_state,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_req_valid,
    output bus_op_e           bus_req_op,
    output logic [IDX_W-1:0]  bus_req_line,
    input  logic              bus_fill_valid,
    input  logic [DATA_W-1:0] bus_fill_data,
    output logic              lrsp_valid,
    output logic [DATA_W-1:0] lrsp_rdata
);

    typedef enum logic {F_IDLE, F_WAIT} fsm_e;

    fsm_e              fsm_q;
    logic [IDX_W-1:0]  pend_line_q;
    logic              pend_wr_q;
    logic [DATA_W-1:0] pend_wdata_q;
    bus_op_e           pend_op_q;
    logic              accept, hit, fill_done;
    bus_op_e           need_op;

    assign lreq_ready = (fsm_q == F_IDLE) && !snp_valid;
    assign accept     = lreq_valid && lreq_ready;
    assign lk_line    = lreq_line;
    assign need_op    = miss_op(lk_state, lreq_write);
    assign hit        = accept && (need_op == OP_NONE);
    assign fill_done  = (fsm_q == F_WAIT) && bus_fill_valid;

    always_comb begin
        wr_en    = 1'b0;
        wr_line  = lreq_line;
        wr_state = ST_E;
        wr_data  = lreq_wdata;
        if (fill_done) begin
            wr_en    = 1'b1;
            wr_line  = pend_line_q;
            wr_state = pend_wr_q ? ST_E : ST_S;
            wr_data  = pend_wr_q ? pend_wdata_q : bus_fill_data;
        end else if (hit && lreq_write) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q        <= F_IDLE;
            pend_line_q  <= '0;
            pend_wr_q    <= 1'b0;
            pend_wdata_q <= '0;
            pend_op_q    <= OP_NONE;
            lrsp_valid   <= 1'b0;
            lrsp_rdata   <= '0;
        end else begin
            lrsp_valid <= hit || fill_done;
            if (fill_done) begin
                lrsp_rdata <= wr_data;
                fsm_q      <= F_IDLE;
                pend_op_q  <= OP_NONE;
            end else if (hit) begin
                lrsp_rdata <= lreq_write ? lreq_wdata : lk_data;
            end else if (accept) begin
                fsm_q        <= F_WAIT;
                pend_line_q  <= lreq_line;
                pend_wr_q    <= lreq_write;
                pend_wdata_q <= lreq_wdata;
                pend_op_q    <= need_op;
            end
        end
    end

    assign bus_req_valid = (fsm_q == F_WAIT);
    assign bus_req_op    = pend_op_q;
    assign bus_req_line  = pend_line_q;

    // R3 / R5: an outstanding request holds op and line until its fill
    p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_fill_valid) |=>
            (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_line)));

    // R3: a read to an Invalid line goes out as a bus read
    p_read_miss_op_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !lreq_write && lk_state == ST_I) |=>
            (bus_req_valid && bus_req_op == OP_RD));

    // R5: a write to a Shared line goes out as an upgrade
    p_write_upg_op_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && lreq_write && lk_state == ST_S) |=>
            (bus_req_valid && bus_req_op == OP_UPG));

    // R4: a write to an Exclusive line completes with no bus traffic
    p_write_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && lreq_write && lk_state == ST_E) |=>
            (lrsp_valid && !bus_req_valid));

    // R10: no new local access while a bus request is outstanding
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !lreq_ready);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lreq_valid,
    input  logic              lreq_write,
    input  logic [IDX_W-1:0]  lreq_line,
    input  logic [DATA_W-1:0] lreq_wdata,
    output logic              lreq_ready,
    output logic              lrsp_valid,
    output logic [DATA_W-1:0] lrsp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [IDX_W-1:0]  bus_req_line,
    input  logic              bus_fill_valid,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [IDX_W-1:0]  snp_line,
    output logic              snp_supply,
    output logic              snp_wb,
    output logic [DATA_W-1:0] snp_data
);

    logic [IDX_W-1:0]  lk_line;
    line_st_e          lk_state;
    logic [DATA_W-1:0] lk_data;
    line_st_e          sn_cur_state;
    logic [DATA_W-1:0] sn_cur_data;
    logic              sn_upd;
    line_st_e          sn_state;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_line;
    line_st_e          wr_state;
    logic [DATA_W-1:0] wr_data;
    bus_op_e           req_op;
    bus_op_e           snp_op_e;

    assign snp_op_e   = bus_op_e'(snp_op);
    assign bus_req_op = req_op;

    coh_line_table #(.NLINES(NLINES), .DATA_W(DATA_W)) u_tab (
        .clk          (clk),
        .rst          (rst),
        .lk_line      (lk_line),
        .lk_state     (lk_state),
        .lk_data      (lk_data),
        .sn_line      (snp_line),
        .sn_cur_state (sn_cur_state),
        .sn_cur_data  (sn_cur_data),
        .sn_upd       (sn_upd),
        .sn_state     (sn_state),
        .wr_en        (wr_en),
        .wr_line      (wr_line),
        .wr_state     (wr_state),
        .wr_data      (wr_data)
    );

    coh_snoop_unit #(.DATA_W(DATA_W)) u_snp (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_op    (snp_op_e),
        .cur_state (sn_cur_state),
        .cur_data  (sn_cur_data),
        .upd       (sn_upd),
        .nxt_state (sn_state),
        .supply    (snp_supply),
        .wb        (snp_wb),
        .data      (snp_data)
    );

    coh_req_fsm #(.NLINES(NLINES), .DATA_W(DATA_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .lreq_valid     (lreq_valid),
        .lreq_write     (lreq_write),
        .lreq_line      (lreq_line),
        .lreq_wdata     (lreq_wdata),
        .lreq_ready     (lreq_ready),
        .snp_valid      (snp_valid),
        .lk_line        (lk_line),
        .lk_state       (lk_state),
        .lk_data        (lk_data),
        .wr_en          (wr_en),
        .wr_line        (wr_line),
        .wr_state       (wr_state),
        .wr_data        (wr_data),
        .bus_req_valid  (bus_req_valid),
        .bus_req_op     (req_op),
        .bus_req_line   (bus_req_line),
        .bus_fill_valid (bus_fill_valid),
        .bus_fill_data  (bus_fill_data),
        .lrsp_valid     (lrsp_valid),
        .lrsp_rdata     (lrsp_rdata)
    );

    // R10: a snoop in flight blocks local acceptance
    p_snoop_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !lreq_ready);

    // R2: a completed hit never coincides with a fresh bus request start
    p_rsp_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
        (lrsp_valid && !bus_req_valid) |=> !bus_req_valid || !lrsp_valid);

endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;

    localparam int NL = 8;
    localparam int DW = 32;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst;
    logic          lreq_valid, lreq_write;
    logic [IW-1:0] lreq_line;
    logic [DW-1:0] lreq_wdata;
    logic          lreq_ready, lrsp_valid;
    logic [DW-1:0] lrsp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_op;
    logic [IW-1:0] bus_req_line;
    logic          bus_fill_valid;
    logic [DW-1:0] bus_fill_data;
    logic          snp_valid;
    logic [1:0]    snp_op;
    logic [IW-1:0] snp_line;
    logic          snp_supply, snp_wb;
    logic [DW-1:0] snp_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    coh_line_ctrl #(.NLINES(NL), .DATA_W(DW)) uut (.*);

    task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // exp_op 0 means a hit is expected
    task automatic local_access(input logic w, input int line, input logic [DW-1:0] wd,
                                input logic [1:0] exp_op, input logic [DW-1:0] fill,
                                input logic [DW-1:0] exp_rd, input string rq);
        @(negedge clk);
        check({rq, " ready before access"}, DW'(lreq_ready), 1);
        lreq_valid = 1'b1; lreq_write = w; lreq_line = IW'(line); lreq_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        lreq_valid = 1'b0;
        if (exp_op == 2'd0) begin
            check({rq, " hit rsp_valid"}, DW'(lrsp_valid), 1);
            check({rq, " hit no bus req"}, DW'(bus_req_valid), 0);
            check({rq, " hit data"}, lrsp_rdata, exp_rd);
        end else begin
            check({rq, " bus req valid"}, DW'(bus_req_valid), 1);
            check({rq, " bus req op"}, DW'(bus_req_op), DW'(exp_op));
            check({rq, " bus req line"}, DW'(bus_req_line), DW'(line));
            check({rq, " R10 busy not ready"}, DW'(lreq_ready), 0);
            @(posedge clk);
            @(negedge clk);
            check({rq, " R3 req held"}, DW'(bus_req_valid), 1);
            bus_fill_valid = 1'b1; bus_fill_data = fill;
            @(posedge clk);
            @(negedge clk);
            bus_fill_valid = 1'b0;
            check({rq, " fill rsp_valid"}, DW'(lrsp_valid), 1);
            check({rq, " fill data"}, lrsp_rdata, exp_rd);
            check({rq, " req released"}, DW'(bus_req_valid), 0);
        end
    endtask

    task automatic snoop(input logic [1:0] op, input int line, input logic sup,
                         input logic wb, input logic [DW-1:0] exp_d, input string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_line = IW'(line);
        #1;
        check({rq, " R10 snoop blocks ready"}, DW'(lreq_ready), 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'd0;
        check({rq, " supply"}, DW'(snp_supply), DW'(sup));
        check({rq, " writeback"}, DW'(snp_wb), DW'(wb));
        if (sup) check({rq, " supply data"}, snp_data, exp_d);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready", DW'(lreq_ready), 1);
        check("R1 no bus req", DW'(bus_req_valid), 0);
        check("R1 no rsp", DW'(lrsp_valid), 0);
        check("R1 no supply", DW'(snp_supply), 0);
        snoop(2'd1, 7, 1'b0, 1'b0, '0, "R1 line7 invalid after reset");
    endtask

    task automatic t_read_paths;
        local_access(1'b0, 0, '0, 2'd1, 32'h0000_00A5, 32'h0000_00A5, "R3 read miss");
        local_access(1'b0, 0, '0, 2'd0, '0, 32'h0000_00A5, "R2 read hit shared");
        snoop(2'd1, 0, 1'b0, 1'b0, '0, "R9 snoop read to shared");
        local_access(1'b0, 0, '0, 2'd0, '0, 32'h0000_00A5, "R9 still shared");
    endtask

    task automatic t_write_paths;
        local_access(1'b1, 0, 32'h1111, 2'd3, 32'hDEAD, 32'h1111, "R5 upgrade from shared");
        local_access(1'b1, 0, 32'h2222, 2'd0, '0, 32'h2222, "R4 write hit exclusive");
        local_access(1'b0, 0, '0, 2'd0, '0, 32'h2222, "R2 read hit exclusive");
    endtask

    task automatic t_snoop_exclusive;
        snoop(2'd1, 0, 1'b1, 1'b1, 32'h2222, "R6 snoop read to exclusive");
        local_access(1'b1, 0, 32'h3333, 2'd3, 32'hBEEF, 32'h3333, "R6 line now shared");
        snoop(2'd2, 0, 1'b1, 1'b0, 32'h3333, "R7 snoop rdx to exclusive");
        local_access(1'b0, 0, '0, 2'd1, 32'h4444, 32'h4444, "R7 line now invalid");
    endtask

    task automatic t_write_miss;
        local_access(1'b1, 5, 32'h55, 2'd2, 32'hF00D, 32'h55, "R5 write miss rdx");
        local_access(1'b0, 0, '0, 2'd0, '0, 32'h4444, "R5 other line untouched");
        snoop(2'd3, 5, 1'b1, 1'b0, 32'h55, "R7 snoop upgrade to exclusive");
        local_access(1'b1, 5, 32'h66, 2'd2, 32'h0, 32'h66, "R7 line5 invalid");
    endtask

    task automatic t_snoop_shared_inv;
        snoop(2'd3, 0, 1'b0, 1'b0, '0, "R8 snoop upgrade to shared");
        local_access(1'b0, 0, '0, 2'd1, 32'h7777, 32'h7777, "R8 line0 invalid");
        snoop(2'd2, 3, 1'b0, 1'b0, '0, "R9 snoop rdx to invalid");
        local_access(1'b0, 3, '0, 2'd1, 32'h33, 32'h33, "R9 line3 still invalid");
    endtask

    initial begin
        rst = 1'b1;
        lreq_valid = 0; lreq_write = 0; lreq_line = '0; lreq_wdata = '0;
        bus_fill_valid = 0; bus_fill_data = '0;
        snp_valid = 0; snp_op = 2'd0; snp_line = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_paths();
        t_write_paths();
        t_snoop_exclusive();
        t_write_miss();
        t_snoop_shared_inv();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule